// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block receives asynchronous serial characters on a single input line. It measures the line on an oversample strobe that runs at sixteen times the bit rate. Each start, data and stop bit is resolved by a three-sample majority vote taken near the middle of its bit period. Characters carry 8 or 9 data bits, least-significant bit first. Each finished character goes into a two-entry queue, together with its ninth bit and a framing-error mark. A host pops the queue through a read strobe and sees the head entry on the data outputs.

Control comes from four level inputs: a port enable, a continuous-receive enable, a 9-bit mode select and an address-filter enable. The address filter is meant for multi-drop links. While it is on in 9-bit mode, only characters whose ninth bit is set reach the queue. An overrun stops all further reception until continuous-receive is dropped. The strobe that sets the bit rate comes from outside the block.

Top module: `serial_rx_engine`

## Requirements
- R1: After reset, idle_o is 1, and ready_o, overrun_o, frame_err_o, bit9_o and rd_data_o are all 0.
- R2: A start is recognised when the synchronised line is low on an oversample strobe. If the majority of the samples taken at oversample counts 7, 8 and 9 is high, the start is treated as a glitch: the receiver returns to idle and queues no word.
- R3: With nine_bit_i at 0, a frame is one low start bit, 8 data bits LSB first and one stop bit, each 16 strobes long. The data appears on rd_data_o and bit9_o reads 0.
- R4: With nine_bit_i at 1, a frame carries 9 data bits LSB first. Data bits 0 to 7 appear on rd_data_o and data bit 8 appears on bit9_o.
- R5: A stop bit that votes 0 sets frame_err_o for that entry. The word is still queued.
- R6: The queue holds two entries. ready_o is 1 while it is not empty. A one-cycle rd_i pops the head. Data, ninth bit and framing mark always reflect the current head, and all read 0 when the queue is empty.
- R7: A word that completes while both entries are full is dropped and sets overrun_o. The two stored entries stay readable in order.
- R8: While overrun_o is 1, no new frame is received. overrun_o clears in the cycle after cont_rx_i is low.
- R9: With nine_bit_i and addr_det_i both at 1, words whose ninth bit is 0 are discarded and ready_o stays 0. With addr_det_i at 0, every word is queued.
- R10: idle_o is 0 while a frame is being shifted in. While port_en_i or cont_rx_i is 0, the receiver stays idle and ignores the line.
- R11: With port_en_i at 0, the queue is emptied and overrun_o is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversample strobe, 16 per bit period |
| rx_i | input | 1 | Serial line, idle high |
| port_en_i | input | 1 | Port enable; low empties the queue |
| cont_rx_i | input | 1 | Continuous-receive enable; low clears overrun |
| nine_bit_i | input | 1 | Selects 9 data bits per frame |
| addr_det_i | input | 1 | Queues only words with ninth bit 1 (in 9-bit mode) |
| rd_i | input | 1 | Pop strobe for the queue head |
| rd_data_o | output | 8 | Head entry data |
| bit9_o | output | 1 | Head entry ninth bit |
| frame_err_o | output | 1 | Head entry framing error |
| overrun_o | output | 1 | Sticky overrun flag |
| ready_o | output | 1 | Queue not empty |
| idle_o | output | 1 | No frame in progress |

## Verification
The bench sweeps all 256 byte values through the 8-bit path. A wrong bit order or an off-by-one shift count would corrupt some of these values. It runs 9-bit words at a slower strobe rate; a bit period counted in clocks instead of strobes would misalign the samples. A short low pulse must not produce a word, which catches a receiver that commits on the edge alone. Three words without reads must keep the first two in order and drop the third. The bench then checks that reception stays stalled until cont_rx_i is toggled. A queue that overwrites its tail or loses the sticky state fails there. The bench also checks that a framing mark belongs to its own entry and moves with the head on a pop, and that the address filter drops and then accepts words.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_DATA, ST_STOP} rx_state_e;

  typedef struct packed {
    logic          ferr;
    logic          bit9;
    logic [DW-1:0] data;
  } rx_word_t;
endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [1:0] sr;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sr <= 2'b11;
    else         sr <= {sr[0], d_i};
  assign q_o = sr[1];
endmodule

// File: rtl/serial_rx_bitfsm.sv
module serial_rx_bitfsm
  import serial_rx_pkg::*;
#(
  parameter int OS = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rx_i,
  input  logic     run_i,
  input  logic     nine_i,
  output logic     valid_o,
  output rx_word_t word_o,
  output logic     idle_o
);
  localparam int CW = $clog2(OS);
  localparam logic [CW-1:0] S0   = CW'(OS/2 - 1);
  localparam logic [CW-1:0] S2   = CW'(OS/2 + 1);
  localparam logic [CW-1:0] SDEC = CW'(OS/2 + 2);
  localparam logic [CW-1:0] LAST = CW'(OS - 1);

  rx_state_e      st;
  logic [CW-1:0]  cnt;
  logic [2:0]     vote;
  logic [3:0]     bidx;
  logic [DW:0]    sh;
  logic           nine_q;
  logic           maj;

  assign maj = (vote[0] & vote[1]) | (vote[0] & vote[2]) | (vote[1] & vote[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cnt <= '0; vote <= '0; bidx <= '0;
      sh <= '0; nine_q <= 1'b0; valid_o <= 1'b0; word_o <= '0;
    end else begin
      valid_o <= 1'b0;
      if (!run_i) begin
        st <= ST_IDLE;
      end else if (tick_i) begin
        if (st != ST_IDLE) begin
          cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
          if (cnt >= S0 && cnt <= S2) vote <= {vote[1:0], rx_i};
        end
        unique case (st)
          ST_IDLE: if (!rx_i) begin
            st <= ST_START; cnt <= '0; bidx <= '0; nine_q <= nine_i;
          end
          ST_START: if (cnt == LAST) st <= maj ? ST_IDLE : ST_DATA;
          ST_DATA: if (cnt == LAST) begin
            sh <= {maj, sh[DW:1]};
            if (bidx == (nine_q ? 4'(DW) : 4'(DW-1))) st <= ST_STOP;
            else bidx <= bidx + 1'b1;
          end
          ST_STOP: if (cnt == SDEC) begin
            st <= ST_IDLE;
            valid_o <= 1'b1;
            word_o.ferr <= ~maj;
            word_o.bit9 <= nine_q & sh[DW];
            word_o.data <= nine_q ? sh[DW-1:0] : sh[DW:1];
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign idle_o = (st == ST_IDLE);
endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import serial_rx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     flush_i,
  input  logic     push_i,
  input  rx_word_t word_i,
  input  logic     pop_i,
  output rx_word_t head_o,
  output logic     not_empty_o,
  output logic     full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rx_word_t      mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp <= '0; rp <= '0; cnt <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (flush_i) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (push_i) begin
        mem[wp] <= word_i;
        wp <= nxt(wp);
      end
      if (pop_i) rp <= nxt(rp);
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign not_empty_o = (cnt != '0);
  assign full_o      = (cnt == CW'(DEPTH));
  assign head_o      = not_empty_o ? mem[rp] : '0;
endmodule

// File: rtl/serial_rx_engine.sv
module serial_rx_engine
  import serial_rx_pkg::*;
#(
  parameter int OS    = 16,
  parameter int DEPTH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          os_tick_i,
  input  logic          rx_i,
  input  logic          port_en_i,
  input  logic          cont_rx_i,
  input  logic          nine_bit_i,
  input  logic          addr_det_i,
  input  logic          rd_i,
  output logic [DW-1:0] rd_data_o,
  output logic          bit9_o,
  output logic          frame_err_o,
  output logic          overrun_o,
  output logic          ready_o,
  output logic          idle_o
);
  logic     rx_s, run, wvalid, accept, push, pop, full, nempty;
  rx_word_t word, head;

  serial_rx_sync u_sync (.clk_i, .rst_ni, .d_i(rx_i), .q_o(rx_s));

  assign run = port_en_i & cont_rx_i & ~overrun_o;

  serial_rx_bitfsm #(.OS(OS)) u_fsm (
    .clk_i, .rst_ni, .tick_i(os_tick_i), .rx_i(rx_s), .run_i(run),
    .nine_i(nine_bit_i), .valid_o(wvalid), .word_o(word), .idle_o(idle_o)
  );

  assign accept = wvalid & ~(nine_bit_i & addr_det_i & ~word.bit9);
  assign pop    = rd_i & nempty;
  assign push   = accept & (~full | pop);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                       overrun_o <= 1'b0;
    else if (!port_en_i || !cont_rx_i) overrun_o <= 1'b0;
    else if (accept && full && !pop)   overrun_o <= 1'b1;

  serial_rx_queue #(.DEPTH(DEPTH)) u_q (
    .clk_i, .rst_ni, .flush_i(~port_en_i), .push_i(push), .word_i(word),
    .pop_i(pop), .head_o(head), .not_empty_o(nempty), .full_o(full)
  );

  assign ready_o     = nempty;
  assign rd_data_o   = head.data;
  assign bit9_o      = head.bit9;
  assign frame_err_o = head.ferr;
endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       port_en_i,
  input logic       cont_rx_i,
  input logic       rd_i,
  input logic       overrun_o,
  input logic       ready_o,
  input logic       idle_o
);
  assert_ovr_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cont_rx_i |=> !overrun_o);
  assert_ovr_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && cont_rx_i && port_en_i |=> overrun_o);
  assert_ovr_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> ready_o);
  assert_hold_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_en_i || !cont_rx_i) |=> idle_o);
  assert_ready_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !rd_i && port_en_i |=> ready_o);
  assert_flush_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_en_i |=> (!ready_o && !overrun_o));
endmodule

bind serial_rx_engine serial_rx_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .port_en_i(port_en_i), .cont_rx_i(cont_rx_i),
  .rd_i(rd_i), .overrun_o(overrun_o), .ready_o(ready_o), .idle_o(idle_o)
);

// File: tb/sim_serial_rx_engine.sv
`timescale 1ns/1ps
module sim_serial_rx_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rx = 1'b1, port_en = 1'b1, cont_rx = 1'b1, nine = 1'b0, addr_det = 1'b0, rd = 1'b0;
  logic [7:0] dout;
  logic b9, fe, ovr, rdy, idl, tick;
  int div = 1, tcnt = 0, checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) tcnt <= (tcnt >= div - 1) ? 0 : tcnt + 1;
  assign tick = (tcnt == 0);

  serial_rx_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .os_tick_i(tick), .rx_i(rx), .port_en_i(port_en),
    .cont_rx_i(cont_rx), .nine_bit_i(nine), .addr_det_i(addr_det), .rd_i(rd),
    .rd_data_o(dout), .bit9_o(b9), .frame_err_o(fe), .overrun_o(ovr),
    .ready_o(rdy), .idle_o(idl)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx = b;
    repeat (16 * div) @(negedge clk);
  endtask

  task automatic send(input logic [8:0] v, input bit nb, input bit stop_ok);
    drive_bit(1'b0);
    for (int i = 0; i < (nb ? 9 : 8); i++) drive_bit(v[i]);
    drive_bit(stop_ok);
    rx = 1'b1;
    repeat (3 * 16 * div) @(negedge clk);
  endtask

  task automatic pop();
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic expect_head(input string req, input logic [7:0] d, input logic b, input logic f);
    check({req, " ready"}, rdy, 1);
    check({req, " data"}, dout, d);
    check({req, " bit9"}, b9, b);
    check({req, " ferr"}, fe, f);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 idle", idl, 1);
    check("R1 ready", rdy, 0);
    check("R1 overrun", ovr, 0);
    check("R1 data", {dout, b9, fe}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3 full 8-bit sweep
    for (int v = 0; v < 256; v++) begin
      send(9'(v), 0, 1);
      expect_head("R3", 8'(v), 0, 0);
      pop();
      check("R6 drained", rdy, 0);
    end

    // R4 9-bit words at slower strobe
    div = 3;
    for (int k = 0; k < 6; k++) begin
      logic [8:0] w;
      w = 9'((k * 83 + 5) ^ (k[0] ? 9'h100 : 9'h000));
      nine = 1'b1;
      send(w, 1, 1);
      expect_head("R4", w[7:0], w[8], 0);
      pop();
    end
    div = 1;

    // R2 glitch start rejected
    rx = 1'b0;
    repeat (4) @(negedge clk);
    rx = 1'b1;
    repeat (64) @(negedge clk);
    check("R2 glitch ready", rdy, 0);
    check("R2 glitch idle", idl, 1);

    // R10 idle low mid frame
    nine = 1'b0;
    fork
      send(9'h3c, 0, 1);
      begin repeat (50) @(negedge clk); check("R10 busy", idl, 0); end
    join
    expect_head("R10 word", 8'h3c, 0, 0);
    pop();

    // R5 + R6 per-entry framing mark follows head
    send(9'ha5, 0, 0);
    send(9'h5a, 0, 1);
    expect_head("R5 bad stop", 8'ha5, 0, 1);
    pop();
    expect_head("R6 head moves", 8'h5a, 0, 0);
    pop();
    check("R6 empty zero", {dout, b9, fe}, 0);

    // R7 overrun
    send(9'h11, 0, 1);
    send(9'h22, 0, 1);
    send(9'h33, 0, 1);
    check("R7 overrun", ovr, 1);
    // R8 stalled
    send(9'h44, 0, 1);
    expect_head("R7 first", 8'h11, 0, 0);
    pop();
    expect_head("R7 second", 8'h22, 0, 0);
    pop();
    check("R8 no new word", rdy, 0);
    check("R8 sticky", ovr, 1);
    cont_rx = 1'b0;
    @(negedge clk);
    check("R8 cleared", ovr, 0);
    cont_rx = 1'b1;
    send(9'h55, 0, 1);
    expect_head("R8 resumed", 8'h55, 0, 0);
    pop();

    // R9 address filter
    nine = 1'b1; addr_det = 1'b1;
    send(9'h0aa, 1, 1);
    check("R9 data word dropped", rdy, 0);
    send(9'h1c3, 1, 1);
    expect_head("R9 address word", 8'hc3, 1, 0);
    pop();
    addr_det = 1'b0;
    send(9'h077, 1, 1);
    expect_head("R9 filter off", 8'h77, 0, 0);
    pop();
    nine = 1'b0;

    // R10 receive disabled ignores line
    cont_rx = 1'b0;
    send(9'h66, 0, 1);
    check("R10 disabled", rdy, 0);
    check("R10 idle held", idl, 1);
    cont_rx = 1'b1;

    // R11 port disable flushes
    send(9'h99, 0, 1);
    check("R11 pre", rdy, 1);
    port_en = 1'b0;
    @(negedge clk);
    check("R11 flushed", rdy, 0);
    port_en = 1'b1;
    send(9'h81, 0, 1);
    expect_head("R11 after", 8'h81, 0, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule